// File: doc/BRIEF.md
# Byte-Addressable Data Space Controller

This block is the data memory space of a small 16-bit processor. The space is addressed by 16-bit byte addresses, 64 KB or 32K words in all. The controller has two ports, one for reads and one for writes, each fed by its own address generator. Both ports can be active in the same cycle. Each access carries a byte/word size flag. The write port also carries data and an enable.

Every address is sorted into one of four regions. The special-function register region and the program-memory visibility window are handed to external request ports. Internal data RAM is held inside the block as 16-bit words with a separate write enable per byte lane. The unimplemented hole returns zero and drops writes. Read results come back one cycle after the request, whichever region served them.

Top module: `dspace_ctrl`

## Requirements
- R1: The region map is as follows. An address with bit 15 set goes to the program window. 0x0000–0x07FF is the SFR region. 0x0800–0x1FFF is data RAM. 0x2000–0x7FFF is unimplemented. The SFR read strobe and the program read strobe are never high together.
- R2: A word written to RAM is returned by a later word read of the same address. Read data appears on `rd_data` in the cycle after `rd_en` is sampled.
- R3: For a word access, address bit 0 is ignored, so the word is always aligned.
- R4: A byte write stores `wr_data[7:0]` into one lane only: the low byte when address bit 0 is 0, the high byte when it is 1. The other byte of that word keeps its value.
- R5: A byte read returns the lane chosen by address bit 0 (0 selects the low byte, 1 the high byte) in `rd_data[7:0]`, with `rd_data[15:8]` zero. This applies in every region.
- R6: A read from the unimplemented region returns zero, for both byte and word accesses. A write there changes no RAM word and raises no strobe or error.
- R7: A read in the program window raises `pgm_rd_stb` with `pgm_rd_addr` = address bits 14:0. `pgm_rd_data` then appears on `rd_data` one cycle later. A write in the window leaves RAM unchanged and sets `pgm_wr_err` for exactly the following cycle.
- R8: An SFR read raises `sfr_rd_stb` in the same cycle, with the address and size, and `sfr_rd_data` appears on `rd_data` one cycle later. An SFR write raises `sfr_wr_stb` in the same cycle, with the address, size and data.
- R9: When a read and a write hit the same RAM word in the same cycle, the read returns the data held before the write.
- R10: While reset is active, and after it until the first read, `rd_data` is zero and `pgm_wr_err` is low.
- R11: In the cycle after a cycle with `rd_en` low, `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read request |
| rd_addr | input | 16 | Read byte address |
| rd_byte | input | 1 | Read size: 1 byte, 0 word |
| rd_data | output | 16 | Read result, one cycle after request |
| wr_en | input | 1 | Write request |
| wr_addr | input | 16 | Write byte address |
| wr_byte | input | 1 | Write size: 1 byte, 0 word |
| wr_data | input | 16 | Write data (byte writes use bits 7:0) |
| sfr_rd_stb | output | 1 | SFR read strobe |
| sfr_rd_addr | output | 16 | SFR read address |
| sfr_rd_byte | output | 1 | SFR read size |
| sfr_rd_data | input | 16 | SFR read word, valid the cycle after the strobe |
| sfr_wr_stb | output | 1 | SFR write strobe |
| sfr_wr_addr | output | 16 | SFR write address |
| sfr_wr_byte | output | 1 | SFR write size |
| sfr_wr_data | output | 16 | SFR write data |
| pgm_rd_stb | output | 1 | Program window read strobe |
| pgm_rd_addr | output | 15 | Offset within the program window |
| pgm_rd_data | input | 16 | Program window word, valid the cycle after the strobe |
| pgm_wr_err | output | 1 | One-cycle flag for a write to the program window |

## Verification
The only state that lasts past one cycle is the RAM contents and the registered read source, lane and size. A corrupted RAM lane or a wrong byte enable does not show until that word is read back. The bench therefore reads each written word again, after later writes to the same or the neighbouring lane and after writes to the hole or the program window. A wrong read-source register shows in the very next cycle as the wrong region's word, a non-zero hole read, or wrong upper bits on a byte read. The stimulus is arranged so that each of these cases falls in a cycle with a known expected word.

// File: rtl/dspace_pkg.sv
package dspace_pkg;

   typedef enum logic [1:0] {
      RG_SFR  = 2'd0,
      RG_RAM  = 2'd1,
      RG_HOLE = 2'd2,
      RG_PGM  = 2'd3
   } region_e;

   localparam int unsigned DEF_ADDR_W   = 16;
   localparam int unsigned DEF_DATA_W   = 16;
   localparam int unsigned DEF_RAM_BASE = 32'h0800;
   localparam int unsigned DEF_RAM_END  = 32'h2000;

endpackage

// File: rtl/dspace_decode.sv
module dspace_decode
   import dspace_pkg::*;
#(
   parameter int unsigned ADDR_W   = DEF_ADDR_W,
   parameter int unsigned RAM_BASE = DEF_RAM_BASE,
   parameter int unsigned RAM_END  = DEF_RAM_END
) (
   input  logic [ADDR_W-1:0] addr,
   output region_e           region
);

   localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(RAM_BASE);
   localparam logic [ADDR_W-1:0] END_A  = ADDR_W'(RAM_END);

   always_comb begin
      if (addr[ADDR_W-1])
         region = RG_PGM;
      else if (addr < BASE_A)
         region = RG_SFR;
      else if (addr < END_A)
         region = RG_RAM;
      else
         region = RG_HOLE;
   end

endmodule

// File: rtl/dspace_ram.sv
module dspace_ram #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned DEPTH  = 3072,
   localparam int unsigned LANES = DATA_W / 8,
   localparam int unsigned IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rd_en,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_q,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [LANES-1:0]  wr_be,
   input  logic [DATA_W-1:0] wr_d
);

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [7:0] mem [DEPTH];
      logic [7:0] q;

      always_ff @(posedge clk) begin
         if (rd_en)
            q <= mem[rd_idx];
         if (wr_en && wr_be[l])
            mem[wr_idx] <= wr_d[l*8 +: 8];
      end

      assign rd_q[l*8 +: 8] = q;
   end

endmodule

// File: rtl/dspace_ctrl.sv
module dspace_ctrl
   import dspace_pkg::*;
#(
   parameter int unsigned ADDR_W   = DEF_ADDR_W,
   parameter int unsigned DATA_W   = DEF_DATA_W,
   parameter int unsigned RAM_BASE = DEF_RAM_BASE,
   parameter int unsigned RAM_END  = DEF_RAM_END
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_byte,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              wr_byte,
   input  logic [DATA_W-1:0] wr_data,
   output logic              sfr_rd_stb,
   output logic [ADDR_W-1:0] sfr_rd_addr,
   output logic              sfr_rd_byte,
   input  logic [DATA_W-1:0] sfr_rd_data,
   output logic              sfr_wr_stb,
   output logic [ADDR_W-1:0] sfr_wr_addr,
   output logic              sfr_wr_byte,
   output logic [DATA_W-1:0] sfr_wr_data,
   output logic              pgm_rd_stb,
   output logic [ADDR_W-2:0] pgm_rd_addr,
   input  logic [DATA_W-1:0] pgm_rd_data,
   output logic              pgm_wr_err
);

   localparam int unsigned LANES  = DATA_W / 8;
   localparam int unsigned LANE_W = $clog2(LANES);
   localparam int unsigned DEPTH  = (RAM_END - RAM_BASE) / LANES;
   localparam int unsigned IDX_W  = $clog2(DEPTH);
   localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(RAM_BASE);

   if (DATA_W < 16 || (DATA_W % 8) != 0 || (LANES & (LANES - 1)) != 0)
      $error("dspace_ctrl: DATA_W must be a power-of-two number of bytes, at least 16 bits");
   if (RAM_BASE >= RAM_END)
      $error("dspace_ctrl: RAM_BASE must lie below RAM_END");
   if (RAM_END > (1 << (ADDR_W - 1)))
      $error("dspace_ctrl: RAM must fit in the lower half of the space");
   if ((RAM_BASE % LANES) != 0 || (RAM_END % LANES) != 0)
      $error("dspace_ctrl: RAM bounds must be word aligned");
   if (LANE_W + IDX_W > ADDR_W)
      $error("dspace_ctrl: RAM index does not fit in the address");

   // address decode, one decoder per port
   logic [ADDR_W-1:0] port_addr [2];
   region_e           port_rg   [2];

   assign port_addr[0] = rd_addr;
   assign port_addr[1] = wr_addr;

   for (genvar p = 0; p < 2; p++) begin : g_dec
      dspace_decode #(
         .ADDR_W  (ADDR_W),
         .RAM_BASE(RAM_BASE),
         .RAM_END (RAM_END)
      ) u_dec (
         .addr  (port_addr[p]),
         .region(port_rg[p])
      );
   end

   region_e rd_rg, wr_rg;
   assign rd_rg = port_rg[0];
   assign wr_rg = port_rg[1];

   // RAM index and lane controls
   logic [IDX_W-1:0]  rd_idx, wr_idx;
   logic [LANE_W-1:0] rd_lane, wr_lane;
   logic [LANES-1:0]  wr_be;
   logic [DATA_W-1:0] wr_word;
   logic [DATA_W-1:0] ram_q;
   logic              ram_rd, ram_wr;

   assign rd_idx  = IDX_W'((rd_addr - BASE_A) >> LANE_W);
   assign wr_idx  = IDX_W'((wr_addr - BASE_A) >> LANE_W);
   assign rd_lane = rd_addr[LANE_W-1:0];
   assign wr_lane = wr_addr[LANE_W-1:0];
   assign ram_rd  = rd_en && (rd_rg == RG_RAM);
   assign ram_wr  = wr_en && (wr_rg == RG_RAM);
   assign wr_word = wr_byte ? {LANES{wr_data[7:0]}} : wr_data;

   for (genvar l = 0; l < LANES; l++) begin : g_be
      assign wr_be[l] = !wr_byte || (wr_lane == LANE_W'(l));
   end

   dspace_ram #(
      .DATA_W(DATA_W),
      .DEPTH (DEPTH)
   ) u_ram (
      .clk   (clk),
      .rd_en (ram_rd),
      .rd_idx(rd_idx),
      .rd_q  (ram_q),
      .wr_en (ram_wr),
      .wr_idx(wr_idx),
      .wr_be (wr_be),
      .wr_d  (wr_word)
   );

   // external request ports
   assign sfr_rd_stb  = rd_en && (rd_rg == RG_SFR);
   assign sfr_rd_addr = rd_addr;
   assign sfr_rd_byte = rd_byte;
   assign sfr_wr_stb  = wr_en && (wr_rg == RG_SFR);
   assign sfr_wr_addr = wr_addr;
   assign sfr_wr_byte = wr_byte;
   assign sfr_wr_data = wr_data;
   assign pgm_rd_stb  = rd_en && (rd_rg == RG_PGM);
   assign pgm_rd_addr = rd_addr[ADDR_W-2:0];

   // read return state
   region_e           src_q;
   logic              byte_q;
   logic [LANE_W-1:0] lane_q;
   logic              err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q  <= RG_HOLE;
         byte_q <= 1'b0;
         lane_q <= '0;
         err_q  <= 1'b0;
      end else begin
         src_q  <= rd_en ? rd_rg : RG_HOLE;
         byte_q <= rd_byte;
         lane_q <= rd_lane;
         err_q  <= wr_en && (wr_rg == RG_PGM);
      end
   end

   assign pgm_wr_err = err_q;

   logic [DATA_W-1:0] word_sel;

   always_comb begin
      unique case (src_q)
         RG_RAM:  word_sel = ram_q;
         RG_SFR:  word_sel = sfr_rd_data;
         RG_PGM:  word_sel = pgm_rd_data;
         default: word_sel = '0;
      endcase
   end

   assign rd_data = byte_q ? DATA_W'(word_sel[{lane_q, 3'b000} +: 8]) : word_sel;

endmodule

// File: rtl/dspace_chk.sv
module dspace_chk #(
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned RAM_END = 32'h2000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_en,
   input logic [ADDR_W-1:0] rd_addr,
   input logic              rd_byte,
   input logic [DATA_W-1:0] rd_data,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              sfr_rd_stb,
   input logic              sfr_wr_stb,
   input logic              pgm_rd_stb,
   input logic              pgm_wr_err
);

   localparam logic [ADDR_W-1:0] END_A = ADDR_W'(RAM_END);

   a_r1_rd_strobes_excl: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sfr_rd_stb, pgm_rd_stb}));

   a_r5_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_byte) |=> (rd_data[DATA_W-1:8] == '0));

   a_r6_hole_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !rd_addr[ADDR_W-1] && rd_addr >= END_A) |=> (rd_data == '0));

   a_r7_err_after_pgm_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr[ADDR_W-1]) |=> pgm_wr_err);

   a_r7_err_only_for_pgm: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_addr[ADDR_W-1]) |=> !pgm_wr_err);

   a_r8_sfr_wr_lower_half: assert property (@(posedge clk) disable iff (!rst_n)
      sfr_wr_stb |-> (wr_en && !wr_addr[ADDR_W-1]));

   a_r11_idle_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> (rd_data == '0));

endmodule

bind dspace_ctrl dspace_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .RAM_END(RAM_END)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rd_en     (rd_en),
   .rd_addr   (rd_addr),
   .rd_byte   (rd_byte),
   .rd_data   (rd_data),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .sfr_rd_stb(sfr_rd_stb),
   .sfr_wr_stb(sfr_wr_stb),
   .pgm_rd_stb(pgm_rd_stb),
   .pgm_wr_err(pgm_wr_err)
);

// File: tb/dspace_ctrl_tb_top.sv
`timescale 1ns/1ps
module dspace_ctrl_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_en = 1'b0, rd_byte = 1'b0;
   logic [15:0] rd_addr = '0;
   logic [15:0] rd_data;
   logic        wr_en = 1'b0, wr_byte = 1'b0;
   logic [15:0] wr_addr = '0, wr_data = '0;
   logic        sfr_rd_stb, sfr_rd_byte, sfr_wr_stb, sfr_wr_byte;
   logic [15:0] sfr_rd_addr, sfr_wr_addr, sfr_wr_data;
   logic [15:0] sfr_rd_data = 16'hA55A;
   logic        pgm_rd_stb, pgm_wr_err;
   logic [14:0] pgm_rd_addr;
   logic [15:0] pgm_rd_data = 16'h3CC3;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   dspace_ctrl dut_i (
      .clk(clk), .rst_n(rst_n),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_byte(rd_byte), .rd_data(rd_data),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_byte(wr_byte), .wr_data(wr_data),
      .sfr_rd_stb(sfr_rd_stb), .sfr_rd_addr(sfr_rd_addr), .sfr_rd_byte(sfr_rd_byte),
      .sfr_rd_data(sfr_rd_data),
      .sfr_wr_stb(sfr_wr_stb), .sfr_wr_addr(sfr_wr_addr), .sfr_wr_byte(sfr_wr_byte),
      .sfr_wr_data(sfr_wr_data),
      .pgm_rd_stb(pgm_rd_stb), .pgm_rd_addr(pgm_rd_addr), .pgm_rd_data(pgm_rd_data),
      .pgm_wr_err(pgm_wr_err)
   );

   typedef struct packed {
      logic        we;
      logic [15:0] wa;
      logic        wb;
      logic [15:0] wd;
      logic        re;
      logic [15:0] ra;
      logic        rb;
      logic [15:0] exp;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 20;
   // fields: we, wa, wb, wd, re, ra, rb, expected rd_data next cycle, requirement
   localparam vec_t VEC [NV] = '{
      '{1'b1, 16'h0800, 1'b0, 16'h1234, 1'b0, 16'h0000, 1'b0, 16'h0000, 8'd11}, // R11 idle
      '{1'b1, 16'h1FFE, 1'b0, 16'hBEEF, 1'b1, 16'h0800, 1'b0, 16'h1234, 8'd2},  // R2
      '{1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1, 16'h1FFE, 1'b0, 16'hBEEF, 8'd1},  // R1 top of RAM
      '{1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1, 16'h0801, 1'b0, 16'h1234, 8'd3},  // R3
      '{1'b1, 16'h0801, 1'b1, 16'h00AB, 1'b1, 16'h0800, 1'b1, 16'h0034, 8'd5},  // R5 low lane
      '{1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1, 16'h0800, 1'b0, 16'hAB34, 8'd4},  // R4 high lane
      '{1'b1, 16'h0800, 1'b1, 16'h55CD, 1'b1, 16'h0801, 1'b1, 16'h00AB, 8'd5},  // R5 high lane
      '{1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1, 16'h0800, 1'b0, 16'hABCD, 8'd4},  // R4 low lane
      '{1'b1, 16'h0800, 1'b0, 16'h9999, 1'b1, 16'h0800, 1'b0, 16'hABCD, 8'd9},  // R9
      '{1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1, 16'h0800, 1'b0, 16'h9999, 8'd9},  // R9 after
      '{1'b1, 16'h2000, 1'b0, 16'hFFFF, 1'b1, 16'h2000, 1'b0, 16'h0000, 8'd6},  // R6
      '{1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1, 16'h7FFE, 1'b0, 16'h0000, 8'd6},  // R6
      '{1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1, 16'h7FFF, 1'b1, 16'h0000, 8'd6},  // R6 byte
      '{1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1, 16'h0010, 1'b0, 16'hA55A, 8'd8},  // R8
      '{1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1, 16'h0011, 1'b1, 16'h00A5, 8'd8},  // R8 byte
      '{1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1, 16'h8000, 1'b0, 16'h3CC3, 8'd7},  // R7
      '{1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1, 16'hFFFF, 1'b1, 16'h003C, 8'd7},  // R7 byte
      '{1'b1, 16'h8002, 1'b0, 16'h7777, 1'b1, 16'h1FFE, 1'b0, 16'hBEEF, 8'd7},  // R7 no RAM write
      '{1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1, 16'h0800, 1'b0, 16'h9999, 8'd6},  // R6 no RAM write
      '{1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0, 16'h0000, 8'd11}  // R11 idle
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle();
      rd_en = 1'b0; rd_byte = 1'b0; rd_addr = '0;
      wr_en = 1'b0; wr_byte = 1'b0; wr_addr = '0; wr_data = '0;
   endtask

   initial begin
      for (int c = 0; c < 100000; c++) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R10: reset state
      repeat (3) @(negedge clk);
      check("R10 rd_data in reset", 32'(rd_data), 32'h0);
      check("R10 err in reset", 32'(pgm_wr_err), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 rd_data after reset", 32'(rd_data), 32'h0);
      check("R10 err after reset", 32'(pgm_wr_err), 32'h0);

      // vector walk: apply at negedge, check the previous vector's read result
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         if (i > 0)
            check($sformatf("R%0d vec%0d", VEC[i-1].req, i-1), 32'(rd_data), 32'(VEC[i-1].exp));
         wr_en = VEC[i].we; wr_addr = VEC[i].wa; wr_byte = VEC[i].wb; wr_data = VEC[i].wd;
         rd_en = VEC[i].re; rd_addr = VEC[i].ra; rd_byte = VEC[i].rb;
      end
      @(negedge clk);
      check($sformatf("R%0d vec%0d", VEC[NV-1].req, NV-1), 32'(rd_data), 32'(VEC[NV-1].exp));
      idle();

      // R1 / R8: SFR read strobe at the upper SFR boundary
      @(negedge clk);
      rd_en = 1'b1; rd_addr = 16'h07FE; rd_byte = 1'b1;
      #1;
      check("R8 sfr_rd_stb", 32'(sfr_rd_stb), 32'h1);
      check("R8 sfr_rd_addr", 32'(sfr_rd_addr), 32'h07FE);
      check("R8 sfr_rd_byte", 32'(sfr_rd_byte), 32'h1);
      check("R1 no pgm strobe for SFR", 32'(pgm_rd_stb), 32'h0);
      // R1: first RAM address raises no strobe
      @(negedge clk);
      rd_addr = 16'h0800; rd_byte = 1'b0;
      #1;
      check("R1 0x0800 not SFR", 32'(sfr_rd_stb), 32'h0);
      check("R1 0x0800 not pgm", 32'(pgm_rd_stb), 32'h0);
      // R7: program window offset
      @(negedge clk);
      rd_addr = 16'h8ABC;
      #1;
      check("R7 pgm_rd_stb", 32'(pgm_rd_stb), 32'h1);
      check("R7 pgm_rd_addr", 32'(pgm_rd_addr), 32'h0ABC);
      check("R1 no SFR strobe for pgm", 32'(sfr_rd_stb), 32'h0);
      // R6: hole read raises no strobe
      @(negedge clk);
      rd_addr = 16'h4000;
      #1;
      check("R6 hole no sfr strobe", 32'(sfr_rd_stb), 32'h0);
      check("R6 hole no pgm strobe", 32'(pgm_rd_stb), 32'h0);
      idle();

      // R8: SFR write strobe
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 16'h0021; wr_byte = 1'b1; wr_data = 16'h00E7;
      #1;
      check("R8 sfr_wr_stb", 32'(sfr_wr_stb), 32'h1);
      check("R8 sfr_wr_addr", 32'(sfr_wr_addr), 32'h0021);
      check("R8 sfr_wr_byte", 32'(sfr_wr_byte), 32'h1);
      check("R8 sfr_wr_data", 32'(sfr_wr_data), 32'h00E7);
      // R6: hole write raises neither strobe nor error
      @(negedge clk);
      wr_addr = 16'h3000; wr_byte = 1'b0;
      #1;
      check("R6 hole write no strobe", 32'(sfr_wr_stb), 32'h0);
      @(posedge clk); #1;
      check("R6 hole write no err", 32'(pgm_wr_err), 32'h0);

      // R7: program window write error pulse lasts one cycle
      @(negedge clk);
      wr_addr = 16'h8004; wr_data = 16'h1111;
      #1;
      check("R7 pgm write no sfr strobe", 32'(sfr_wr_stb), 32'h0);
      @(posedge clk); #1;
      check("R7 err set", 32'(pgm_wr_err), 32'h1);
      @(negedge clk);
      idle();
      @(posedge clk); #1;
      check("R7 err cleared", 32'(pgm_wr_err), 32'h0);

      // R10: reset in mid-run clears the read return
      @(negedge clk);
      rd_en = 1'b1; rd_addr = 16'h0800;
      @(negedge clk);
      idle();
      check("R2 read before reset", 32'(rd_data), 32'h9999);
      rst_n = 1'b0;
      #1;
      check("R10 rd_data on reset", 32'(rd_data), 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 rd_data after re-reset", 32'(rd_data), 32'h0);

      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule